// File: doc/BRIEF.md
# Tier-Based TDMA Slot Scheduler

This block sequences a repeating synchronisation cycle for one node of a tiered wireless timing network. Tiers count hop distance from the reference node: tier 0 is the reference, tier 1 hears it directly, tier 2 hears only tier 1, and so on. Each cycle holds one time slot per tier, in tier order. In slot k, the nodes of tier k send their beacon and the nodes of tier k+1 correlate it. The node's own tier is a configuration input. From it the scheduler raises a transmit enable in the node's own slot and a receive/correlate enable in the slot of the tier one hop closer to the reference.

A configuration bit can add one more slot at the end of the cycle. In that slot every node transmits together, so that a collective offset can be measured. After the last slot the scheduler spends one clock in a gap with a cycle-end strobe. Timer correction logic uses this gap to adjust the node clock before the next cycle begins. The next cycle is marked by a cycle-start strobe.

The slot length, the tier count, the extra-slot bit and the node tier are sampled together at each cycle start and held for the whole cycle. The cycle therefore always runs with one consistent set of values.

Top module: `tier_slot_sched`

## Requirements
- R1: While reset is high, every output is 0. The first rising edge with reset low starts a cycle, so the clock after it shows slot 0 with cycle_start high.
- R2: Every slot lasts L clocks, where L is the latched slot length and a value of 0 counts as 1. Within a cycle, slot_idx rises by exactly one from slot to slot, starting at 0.
- R3: A cycle holds N tier slots, indices 0 to N-1, where N is the latched tier count and 0 counts as 1. When the extra-slot bit is 1, one further slot with index N follows. The cycle period is slots*L+1 clocks.
- R4: cycle_end is high for exactly one clock, directly after the last slot. During that clock slot_active, tx_en and rx_en are low and slot_idx reads 0. cycle_start follows on the next clock.
- R5: tx_en is high for the whole slot whose index equals the node tier T, provided T<N. A tier-0 node therefore transmits in slot 0 of every cycle.
- R6: rx_en is high for the whole slot with index T-1 when 1<=T<N, and is never high for a tier-0 node. A node of the highest tier (T=N-1) keeps both its receive slot and its transmit slot.
- R7: In the extra slot (index N), all_slot_active and tx_en are high for every node, whatever its tier, and rx_en is low.
- R8: A node with T>=N gets neither tx_en nor rx_en in any tier slot.
- R9: The configuration inputs are captured only at cycle start. A change during a cycle has no effect until the next cycle start.
- R10: cycle_start is high for exactly the first clock of slot 0 and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_slot_len | input | 16 | Slot length in clocks (0 counts as 1) |
| cfg_num_tiers | input | 4 | Number of tiers N (0 counts as 1) |
| cfg_all_slot | input | 1 | Append the all-node transmit slot |
| cfg_my_tier | input | 4 | Tier of this node |
| slot_idx | output | 5 | Current slot index, 0 outside slots |
| slot_active | output | 1 | High while inside a slot |
| cycle_start | output | 1 | High on the first clock of a cycle |
| cycle_end | output | 1 | One-clock gap strobe after the last slot |
| tx_en | output | 1 | Transmit enable for this node |
| rx_en | output | 1 | Receive/correlate enable for this node |
| all_slot_active | output | 1 | High during the all-node slot |

## Verification
The in-line assertions check several properties on every clock:
- the tick counter stays within the slot length;
- the slot index never passes the last slot and steps by one;
- the end strobe lasts a single clock and is always followed by a start strobe;
- transmit and receive are never both high;
- the all-node slot always transmits;
- the latched configuration stays still inside a cycle.

Only the bench's directed scenarios can show the rest, because it requires counting against the configured values:
- that each slot lasts exactly the configured length;
- that the enables fall in the right slot for a given tier;
- that tier counts of zero, of the maximum, and tiers outside the network behave as required;
- that a mid-cycle configuration change appears exactly one cycle later.

// File: rtl/sched_pkg.sv
package sched_pkg;
    parameter int LEN_W  = 16;
    parameter int TIER_W = 4;
    localparam int SLOT_W = TIER_W + 1;

    typedef struct packed {
        logic [LEN_W-1:0]  slot_len;
        logic [TIER_W-1:0] num_tiers;
        logic              all_slot;
        logic [TIER_W-1:0] my_tier;
    } sched_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SLOT = 2'd1,
        PH_GAP  = 2'd2
    } phase_e;

    // Zero length and zero tier count are treated as one.
    function automatic sched_cfg_t sanitize(input sched_cfg_t c);
        sched_cfg_t r;
        r = c;
        if (c.slot_len == '0)  r.slot_len  = LEN_W'(1);
        if (c.num_tiers == '0) r.num_tiers = TIER_W'(1);
        return r;
    endfunction

    function automatic logic [SLOT_W-1:0] last_slot(input sched_cfg_t c);
        return SLOT_W'(c.num_tiers) - SLOT_W'(1) + SLOT_W'(c.all_slot);
    endfunction
endpackage

// File: rtl/cfg_latch.sv
module cfg_latch
    import sched_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  sched_cfg_t cfg_in,
    output sched_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= sanitize(cfg_in);
        end
    end

    // R2/R3: a latched length or tier count is never zero once loaded
    p_cfg_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        !load |-> (cfg_q.slot_len != '0 && cfg_q.num_tiers != '0));
endmodule

// File: rtl/slot_timer.sv
module slot_timer
    import sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LEN_W-1:0]  slot_len,
    input  logic [SLOT_W-1:0] last_idx,
    output logic              load,
    output logic              slot_active,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              cycle_start,
    output logic              cycle_end
);
    phase_e            phase_q;
    logic [SLOT_W-1:0] idx_q;
    logic [LEN_W-1:0]  tick_q;
    logic              slot_done;

    assign slot_done = (tick_q == slot_len - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            tick_q  <= '0;
        end else begin
            case (phase_q)
                PH_SLOT: begin
                    if (slot_done) begin
                        tick_q <= '0;
                        if (idx_q == last_idx) begin
                            phase_q <= PH_GAP;
                            idx_q   <= '0;
                        end else begin
                            idx_q <= idx_q + SLOT_W'(1);
                        end
                    end else begin
                        tick_q <= tick_q + LEN_W'(1);
                    end
                end
                PH_IDLE, PH_GAP: begin
                    phase_q <= PH_SLOT;
                    idx_q   <= '0;
                    tick_q  <= '0;
                end
                default: begin
                    phase_q <= PH_IDLE;
                    idx_q   <= '0;
                    tick_q  <= '0;
                end
            endcase
        end
    end

    assign load        = (phase_q != PH_SLOT);
    assign slot_active = (phase_q == PH_SLOT);
    assign slot_idx    = slot_active ? idx_q : '0;
    assign cycle_start = slot_active && (idx_q == '0) && (tick_q == '0);
    assign cycle_end   = (phase_q == PH_GAP);

    p_tick_range_r2: assert property (@(posedge clk) disable iff (rst)
        slot_active |-> (tick_q < slot_len));
    p_idx_step_r2: assert property (@(posedge clk) disable iff (rst)
        (slot_active && $past(slot_active) && slot_idx != $past(slot_idx))
            |-> (slot_idx == $past(slot_idx) + SLOT_W'(1)));
    p_idx_range_r3: assert property (@(posedge clk) disable iff (rst)
        slot_active |-> (slot_idx <= last_idx));
    p_end_single_r4: assert property (@(posedge clk) disable iff (rst)
        cycle_end |=> !cycle_end);
    p_end_then_start_r4: assert property (@(posedge clk) disable iff (rst)
        cycle_end |=> cycle_start);
    p_start_slot0_r10: assert property (@(posedge clk) disable iff (rst)
        cycle_start |-> (slot_idx == '0 && !cycle_end));
endmodule

// File: rtl/role_decode.sv
module role_decode
    import sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_active,
    input  logic [SLOT_W-1:0] slot_idx,
    input  sched_cfg_t        cfg,
    output logic              tx_en,
    output logic              rx_en,
    output logic              all_active
);
    logic [SLOT_W-1:0] tier_w;
    logic              in_net;

    assign tier_w     = SLOT_W'(cfg.my_tier);
    assign in_net     = (cfg.my_tier < cfg.num_tiers);
    assign all_active = slot_active && cfg.all_slot
                        && (slot_idx == SLOT_W'(cfg.num_tiers));

    always_comb begin
        tx_en = 1'b0;
        rx_en = 1'b0;
        if (slot_active) begin
            if (all_active) begin
                tx_en = 1'b1;
            end else if (in_net) begin
                tx_en = (slot_idx == tier_w);
                rx_en = (cfg.my_tier != '0) && (slot_idx == tier_w - SLOT_W'(1));
            end
        end
    end

    p_txrx_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(tx_en && rx_en));
    p_all_tx_r7: assert property (@(posedge clk) disable iff (rst)
        all_active |-> (tx_en && !rx_en));
    p_master_norx_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg.my_tier == '0) |-> !rx_en);
endmodule

// File: rtl/tier_slot_sched.sv
module tier_slot_sched
    import sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LEN_W-1:0]  cfg_slot_len,
    input  logic [TIER_W-1:0] cfg_num_tiers,
    input  logic              cfg_all_slot,
    input  logic [TIER_W-1:0] cfg_my_tier,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              slot_active,
    output logic              cycle_start,
    output logic              cycle_end,
    output logic              tx_en,
    output logic              rx_en,
    output logic              all_slot_active
);
    sched_cfg_t cfg_in, cfg_q;
    logic       load;

    assign cfg_in = '{slot_len: cfg_slot_len, num_tiers: cfg_num_tiers,
                      all_slot: cfg_all_slot, my_tier: cfg_my_tier};

    cfg_latch u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    slot_timer u_timer (
        .clk         (clk),
        .rst         (rst),
        .slot_len    (cfg_q.slot_len),
        .last_idx    (last_slot(cfg_q)),
        .load        (load),
        .slot_active (slot_active),
        .slot_idx    (slot_idx),
        .cycle_start (cycle_start),
        .cycle_end   (cycle_end)
    );

    role_decode u_role (
        .clk         (clk),
        .rst         (rst),
        .slot_active (slot_active),
        .slot_idx    (slot_idx),
        .cfg         (cfg_q),
        .tx_en       (tx_en),
        .rx_en       (rx_en),
        .all_active  (all_slot_active)
    );

    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (slot_active && !cycle_start) |-> $stable(cfg_q));
    p_gap_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        cycle_end |-> (!tx_en && !rx_en && !slot_active));
endmodule

// File: tb/tb_tier_slot_sched.sv
`timescale 1ns/1ps
module tb_tier_slot_sched;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_slot_len = 16'd4;
    logic [3:0]  cfg_num_tiers = 4'd3;
    logic        cfg_all_slot = 1'b0;
    logic [3:0]  cfg_my_tier = 4'd1;
    logic [4:0]  slot_idx;
    logic        slot_active, cycle_start, cycle_end, tx_en, rx_en, all_slot_active;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int cur_n = 3, cur_l = 4, cur_all = 0, cur_t = 1;

    always #2.5 clk = ~clk;

    tier_slot_sched dut (
        .clk(clk), .rst(rst),
        .cfg_slot_len(cfg_slot_len), .cfg_num_tiers(cfg_num_tiers),
        .cfg_all_slot(cfg_all_slot), .cfg_my_tier(cfg_my_tier),
        .slot_idx(slot_idx), .slot_active(slot_active),
        .cycle_start(cycle_start), .cycle_end(cycle_end),
        .tx_en(tx_en), .rx_en(rx_en), .all_slot_active(all_slot_active)
    );

    task automatic chk(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", what, got, exp, $time);
        end
    endtask

    // Called at the sample point of the first clock of a cycle;
    // returns at the sample point of the first clock of the next cycle.
    task automatic check_cycle(input int n, input int l, input int all, input int t,
                               input string tag);
        int ne = (n == 0) ? 1 : n;
        int le = (l == 0) ? 1 : l;
        int slots = ne + all;
        for (int s = 0; s < slots; s++) begin
            for (int k = 0; k < le; k++) begin
                bit is_all = (all != 0) && (s == ne);
                bit etx = is_all || (t < ne && s == t);
                bit erx = !is_all && t >= 1 && t < ne && s == t - 1;
                chk({tag, " R2/R3 slot_idx"}, slot_idx, s);
                chk({tag, " R2 slot_active"}, slot_active, 1);
                chk({tag, " R10 cycle_start"}, cycle_start, (s == 0 && k == 0) ? 1 : 0);
                chk({tag, " R4 cycle_end"}, cycle_end, 0);
                chk({tag, " R5/R7/R8 tx_en"}, tx_en, etx);
                chk({tag, " R6/R7/R8 rx_en"}, rx_en, erx);
                chk({tag, " R7 all_slot_active"}, all_slot_active, is_all);
                @(negedge clk);
            end
        end
        chk({tag, " R4 cycle_end gap"}, cycle_end, 1);
        chk({tag, " R4 gap slot_active"}, slot_active, 0);
        chk({tag, " R4 gap slot_idx"}, slot_idx, 0);
        chk({tag, " R4 gap tx_en"}, tx_en, 0);
        chk({tag, " R4 gap rx_en"}, rx_en, 0);
        @(negedge clk);
        chk({tag, " R4 start after gap"}, cycle_start, 1);
    endtask

    // New config applied mid-cycle (R9): the running cycle keeps the old one.
    task automatic scenario(input int n, input int l, input int all, input int t,
                            input string tag);
        cfg_num_tiers = 4'(n);
        cfg_slot_len  = 16'(l);
        cfg_all_slot  = 1'(all);
        cfg_my_tier   = 4'(t);
        check_cycle(cur_n, cur_l, cur_all, cur_t, {tag, " R9 old-cfg"});
        cur_n = n; cur_l = l; cur_all = all; cur_t = t;
        check_cycle(cur_n, cur_l, cur_all, cur_t, tag);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk("R1 reset slot_active", slot_active, 0);
        chk("R1 reset cycle_start", cycle_start, 0);
        chk("R1 reset cycle_end", cycle_end, 0);
        chk("R1 reset tx_en", tx_en, 0);
        chk("R1 reset rx_en", rx_en, 0);
        chk("R1 reset slot_idx", slot_idx, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first cycle_start", cycle_start, 1);
    endtask

    initial begin
        test_reset();
        scenario(3, 2, 1, 2, "highest-tier+all R6/R7");
        scenario(1, 3, 0, 0, "single-tier master R5");
        scenario(0, 0, 0, 0, "zero-clamp R2/R3");
        scenario(4, 1, 1, 7, "outside-tier R8");
        scenario(3, 2, 0, 3, "tier==N R8");
        scenario(15, 2, 1, 14, "max-tiers R3");
        scenario(2, 5, 0, 0, "master R5");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule